// File: doc/BRIEF.md
# Two-Word Serial Frame Transmitter

This block sends a pair of asynchronous serial frames, back to back, whenever a rising edge appears on its send request input. Each frame carries eight data bits taken from a parallel input byte: the first frame uses the first byte and the second frame uses the second byte. Every frame is framed by a start bit and closed by an even-parity bit and a stop bit, for eleven bit slots per frame. Each bit slot lasts 64 system clocks.

Bit slots follow a free-running grid of 64 clocks that starts counting at reset release. The block does not start a frame at the instant of the request. It waits for the next mid-slot point of the grid and then for the next slot boundary after that. The first start bit therefore appears roughly half a bit time or one and a half bit times after the request. The first byte is captured one clock before the first start bit begins. The second byte is captured at the end of the second frame's start bit, so upstream logic can still change it during the first frame.

The line is driven in the inverted sense: the line rests low, a start bit is high, data and parity bits are inverted, and a stop bit is low. An external inverting driver restores the normal polarity. In a typical system the request arrives within a few bit times of a received command, and the transmitted pair answers that command.

Top module: `twoframe_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `txLine` is 0 and `txBusy` is 0.
- R2: A 0-to-1 transition of `sendIn`, sampled on a clock edge while `txBusy` is 0, sets `txBusy` to 1 from the next cycle. `txBusy` stays 1 until the clock edge that ends the second frame's stop bit.
- R3: The slot grid is a count of clock edges since reset release, taken modulo 64. Take the first edge after the request edge whose grid phase is 31. The first start bit begins at the edge 32 clocks after that one. Until then `txLine` stays 0, so the delay from the request edge is 33 to 96 clocks.
- R4: Each bit slot lasts 64 clocks. Each frame sends, in order: a start bit (line 1), data bits 0 to 7 with bit 0 first, each driven inverted, an even-parity bit over the eight data bits driven inverted, and a stop bit (line 0).
- R5: The first frame's data comes from `firstByte` as sampled on the clock edge one cycle before the first start bit begins. Later changes to `firstByte` have no effect on that transmission.
- R6: The second frame's data comes from `secondByte` as sampled on the clock edge that ends the second frame's start bit. Changes to `secondByte` before or after that edge have no effect on that transmission.
- R7: The second frame's start bit begins at the same clock edge that ends the first frame's stop bit, with no idle gap between the frames.
- R8: Rising edges of `sendIn` while `txBusy` is 1 are ignored. A `sendIn` level held high past the end of a transmission does not start a new one.
- R9: Whenever `txBusy` is 0, `txLine` is 0 (the inverted idle level).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sendIn | input | 1 | Send request; a rising edge starts a two-frame transmission |
| firstByte | input | DATA_W | Data for the first frame |
| secondByte | input | DATA_W | Data for the second frame |
| txLine | output | 1 | Serial output, inverted polarity |
| txBusy | output | 1 | High from the accepted request until the second stop bit ends |

## Verification
Each internal error shows up at the ports within one bit slot. A grid counter out of step, or a wrong alignment state, moves the first high start bit by at least one clock. A slot index or frame flag that is off places a wrong level in the very next 64-clock slot. A byte captured at the wrong moment changes a data or parity slot in the frame that uses it. A busy flag that is stuck or released early differs from `txBusy` in the cycle it goes wrong, or it lets a later request start a second transmission that shows on `txLine` within about 96 clocks. The reference model runs next to the design, and every output is compared on every cycle, so the first wrong cycle is reported.

// File: rtl/twoframe_tx_pkg.sv
package twoframe_tx_pkg;

  localparam int SLOT_W = 4;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_ARMED,
    TX_ALIGN,
    TX_SEND
  } txState_t;

  typedef struct packed {
    logic              loadA;
    logic              loadB;
    logic              emit;
    logic [SLOT_W-1:0] slot;
  } txStrobe_t;

endpackage

// File: rtl/twoframe_tx_ctrl.sv
module twoframe_tx_ctrl
  import twoframe_tx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 64
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sendIn,
  output txStrobe_t strobes,
  output logic      busy
);

  localparam int CNT_W     = $clog2(CLKS_PER_BIT);
  localparam int HALF      = CLKS_PER_BIT / 2;
  localparam int LAST_SLOT = DATA_W + 2;

  logic [CNT_W-1:0]  gridCnt;
  logic [SLOT_W-1:0] bitIdx;
  logic              frameSel;
  logic              sendPrev;
  txState_t          state;

  logic midTick, preTick, endTick, sendRise, lastSlot;

  assign midTick  = (gridCnt == CNT_W'(HALF - 1));
  assign preTick  = (gridCnt == CNT_W'(CLKS_PER_BIT - 2));
  assign endTick  = (gridCnt == CNT_W'(CLKS_PER_BIT - 1));
  assign sendRise = sendIn & ~sendPrev;
  assign lastSlot = (bitIdx == SLOT_W'(LAST_SLOT));
  assign busy     = (state != TX_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gridCnt  <= '0;
      sendPrev <= 1'b0;
    end else begin
      gridCnt  <= endTick ? '0 : gridCnt + 1'b1;
      sendPrev <= sendIn;
    end
  end

  always_comb begin
    strobes = '0;
    if (state == TX_ALIGN) begin
      strobes.loadA = preTick;
      if (endTick) begin
        strobes.emit = 1'b1;
        strobes.slot = '0;
      end
    end else if (state == TX_SEND && endTick) begin
      if (!lastSlot) begin
        strobes.emit  = 1'b1;
        strobes.slot  = bitIdx + 1'b1;
        strobes.loadB = frameSel && (bitIdx == '0);
      end else if (!frameSel) begin
        strobes.emit = 1'b1;
        strobes.slot = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= TX_IDLE;
      bitIdx   <= '0;
      frameSel <= 1'b0;
    end else begin
      unique case (state)
        TX_IDLE:  if (sendRise) state <= TX_ARMED;
        TX_ARMED: if (midTick) state <= TX_ALIGN;
        TX_ALIGN: begin
          if (endTick) begin
            state    <= TX_SEND;
            bitIdx   <= '0;
            frameSel <= 1'b0;
          end
        end
        TX_SEND: begin
          if (endTick) begin
            if (!lastSlot) begin
              bitIdx <= bitIdx + 1'b1;
            end else if (!frameSel) begin
              bitIdx   <= '0;
              frameSel <= 1'b1;
            end else begin
              state <= TX_IDLE;
            end
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/twoframe_tx_dpath.sv
module twoframe_tx_dpath
  import twoframe_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobes,
  input  logic [DATA_W-1:0] firstByte,
  input  logic [DATA_W-1:0] secondByte,
  output logic              txLine
);

  localparam int PARITY_SLOT = DATA_W + 1;

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] srcByte;
  logic              parityReg;
  int                slotNum;

  assign srcByte = strobes.loadB ? secondByte : dataReg;
  assign slotNum = int'(strobes.slot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg   <= '0;
      parityReg <= 1'b0;
      txLine    <= 1'b0;
    end else begin
      if (strobes.loadA) begin
        dataReg   <= firstByte;
        parityReg <= ^firstByte;
      end
      if (strobes.emit) begin
        if (slotNum == 0) begin
          txLine <= 1'b1;
        end else if (slotNum <= DATA_W) begin
          txLine  <= ~srcByte[0];
          dataReg <= srcByte >> 1;
          if (strobes.loadB) parityReg <= ^secondByte;
        end else if (slotNum == PARITY_SLOT) begin
          txLine <= ~parityReg;
        end else begin
          txLine <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/twoframe_tx.sv
module twoframe_tx
  import twoframe_tx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sendIn,
  input  logic [DATA_W-1:0] firstByte,
  input  logic [DATA_W-1:0] secondByte,
  output logic              txLine,
  output logic              txBusy
);

  txStrobe_t strobes;

  twoframe_tx_ctrl #(
    .DATA_W      (DATA_W),
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sendIn (sendIn),
    .strobes(strobes),
    .busy   (txBusy)
  );

  twoframe_tx_dpath #(
    .DATA_W(DATA_W)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .firstByte (firstByte),
    .secondByte(secondByte),
    .txLine    (txLine)
  );

endmodule

// File: rtl/twoframe_tx_chk.sv
module twoframe_tx_chk #(
  parameter int DATA_W       = 8,
  parameter int CLKS_PER_BIT = 64
) (
  input logic clk,
  input logic rstN,
  input logic sendIn,
  input logic txLine,
  input logic txBusy
);

  localparam int FRAME_CLKS = 2 * (DATA_W + 3) * CLKS_PER_BIT;
  localparam int MIN_BUSY   = FRAME_CLKS + CLKS_PER_BIT / 2 + 1;
  localparam int MAX_BUSY   = FRAME_CLKS + CLKS_PER_BIT + CLKS_PER_BIT / 2;
  localparam int PH_W       = $clog2(CLKS_PER_BIT);

  logic [PH_W-1:0] phase;
  logic [31:0]     busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      busyLen <= '0;
    end else begin
      phase   <= phase + 1'b1;
      busyLen <= txBusy ? busyLen + 1 : 32'd0;
    end
  end

  // R9: idle line level whenever not busy
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> !txLine);

  // R2: busy only rises after a sampled request level
  p_busy_needs_send_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> $past(sendIn));

  // R4: line changes only on slot boundaries of the grid
  p_slot_edges_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) |-> (phase == '0));

  // R3: busy length covers alignment delay plus both frames
  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txBusy) |-> (busyLen >= 32'(MIN_BUSY) && busyLen <= 32'(MAX_BUSY)));

endmodule

bind twoframe_tx twoframe_tx_chk #(
  .DATA_W      (DATA_W),
  .CLKS_PER_BIT(CLKS_PER_BIT)
) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .sendIn(sendIn),
  .txLine(txLine),
  .txBusy(txBusy)
);

// File: tb/twoframe_tx_tb.sv
`timescale 1ns/1ps
module twoframe_tx_tb_top;

  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sendIn = 1'b0;
  logic [7:0] firstByte = 8'h00;
  logic [7:0] secondByte = 8'h00;
  logic       txLine, txBusy;

  int vectors = 0;
  int errors  = 0;
  bit running = 0;

  always #4 clk = ~clk;

  twoframe_tx dut_i (
    .clk(clk), .rstN(rstN), .sendIn(sendIn),
    .firstByte(firstByte), .secondByte(secondByte),
    .txLine(txLine), .txBusy(txBusy)
  );

  // behavioural reference model
  int     cyc = 0;
  int     mL = 0;
  bit     mBusy = 0, mLine = 0, prevSend = 0, gotA = 0, gotB = 0;
  logic [7:0] mA, mB;
  string  lineTag = "R1";

  always @(posedge clk) begin
    if (rstN) begin
      bit rise;
      rise = sendIn && !prevSend;
      prevSend = sendIn;
      if (mBusy) begin
        if (cyc == mL - 1) begin mA = firstByte; gotA = 1; end
        if (cyc >= mL && (cyc - mL) % BITCLK == 0) begin
          int j, k;
          logic [7:0] cur;
          j = (cyc - mL) / BITCLK;
          if (j == 22) begin
            mBusy = 0; mLine = 0; lineTag = "R9";
          end else begin
            k = j % 11;
            if (j == 12) begin mB = secondByte; gotB = 1; end
            cur = (j < 11) ? mA : mB;
            if (k == 0) mLine = 1;
            else if (k <= 8) mLine = ~cur[k-1];
            else if (k == 9) mLine = ~(^cur);
            else mLine = 0;
            if (j == 11) lineTag = "R7";
            else if (k >= 1 && k <= 8) lineTag = (j < 11) ? "R5" : "R6";
            else lineTag = "R4";
          end
        end
      end else if (rise) begin
        int t;
        mBusy = 1;
        t = cyc + 1;
        while (t % BITCLK != 31) t++;
        mL = t + 32;
        gotA = 0; gotB = 0;
        lineTag = "R3";
      end
      cyc++;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check(lineTag, txLine, mLine, "txLine");
      check("R2", txBusy, mBusy, "txBusy");
    end
  end

  task automatic sendPair(input int ph, input logic [7:0] a, input logic [7:0] b,
                          input bit extraEdge, input bit holdHigh);
    firstByte  = a;
    secondByte = ~b;
    while (cyc % BITCLK != ph) @(negedge clk);
    sendIn = 1'b1;
    repeat (3) @(negedge clk);
    if (!holdHigh) sendIn = 1'b0;
    while (!gotA) @(negedge clk);
    firstByte = ~a;                       // R5: too late to matter
    if (extraEdge) begin                  // R8: edge while busy
      sendIn = 1'b0; @(negedge clk);
      sendIn = 1'b1; repeat (2) @(negedge clk);
      sendIn = 1'b0;
    end
    while (cyc < mL + 11 * BITCLK) @(negedge clk);
    secondByte = b;                       // R6: value present at latch edge
    while (!gotB) @(negedge clk);
    secondByte = ~b;                      // R6: change after latch ignored
    while (mBusy) @(negedge clk);
    repeat (150) @(negedge clk);
    check("R8", txBusy, 1'b0, "no retrigger busy");
    check("R8", txLine, 1'b0, "no retrigger line");
    sendIn = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", txLine, 1'b0, "reset txLine");
    check("R1", txBusy, 1'b0, "reset txBusy");
    rstN = 1'b1;
    @(negedge clk);
    check("R1", txLine, 1'b0, "post-reset txLine");
    check("R1", txBusy, 1'b0, "post-reset txBusy");
    running = 1;
    sendPair(30, 8'hA5, 8'h3C, 0, 0);   // R3 shortest delay
    sendPair(31, 8'h00, 8'hFF, 1, 0);   // R3 longest delay, R8
    sendPair(32, 8'hFF, 8'h00, 0, 1);   // R8 level held high
    sendPair(0,  8'h01, 8'h80, 1, 0);
    sendPair(63, 8'h5A, 8'hC3, 0, 0);
    sendPair(10, 8'h80, 8'h01, 0, 0);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule